// File: doc/BRIEF.md
# Half-Duplex Carrier Deference Controller

This block decides when a half-duplex Ethernet transmitter may use the medium again after carrier activity. It watches carrier sense and, once carrier goes away, times an inter-frame gap of 96 bit times. When that gap has run out it raises a single gap-complete flag. The transmit process uses that flag as its permission to start.

Two deferral styles are available, chosen by a mode input. In the split style, the gap has a restartable first phase of 64 bit times and a committed second phase of 32 bit times. Carrier in the first phase sends the machine back to waiting for an idle line. Carrier in the second phase is ignored, which keeps medium access fair. In the fixed style, one 96-bit-time gap always runs to completion. The transmit process can also force the machine into any of its states through an entry request.

Delays are counted in clock cycles. A parameter sets how many clock cycles make one 100 ns bit time. Carrier sense is brought into the clock domain through a two-flop synchroniser before the state machine sees it.

Top module: `carrier_defer`

## Requirements
- R1: After reset, ifg_done_o is high: the machine is in the gap-complete state.
- R2: A high carrier sense reaches the state machine through two synchronising flops. From the gap-complete state, ifg_done_o falls on the third clock edge after crs_i rises. The machine then holds in the busy state, with ifg_done_o low, for as long as carrier stays high.
- R3: In split mode (dfr_dis_i = 0), once carrier falls the machine runs 64 bit times of first phase, then 32 bit times of second phase. ifg_done_o rises 3 + 96·CYC_PER_BIT edges after crs_i falls.
- R4: In split mode, a carrier that reaches the state machine during the first phase, up to and including its last cycle, returns the machine to busy. A full new gap is timed from the next carrier fall.
- R5: In split mode, carrier during the second phase has no effect. ifg_done_o rises at the same edge as if carrier had stayed low.
- R6: In fixed mode (dfr_dis_i = 1), the gap is a single 96-bit-time delay. Carrier at any point in that delay has no effect on when ifg_done_o rises.
- R7: dfr_dis_i is sampled only when a gap begins, as the machine leaves busy. A change of dfr_dis_i during a running gap does not alter that gap.
- R8: When enter_i is high, the machine loads the state coded on enter_state_i at the next edge and restarts its timer. Codes: 0 busy, 1 first phase, 2 second phase, 3 fixed gap, 4 gap complete. An entry request takes priority over every other transition.
- R9: Entry requests with codes 5 to 7 are ignored and do not disturb a running gap.
- R10: In the gap-complete state, ifg_done_o stays high until a valid entry request arrives or synchronised carrier is seen. Synchronised carrier moves the machine to busy.
- R11: ifg_done_o is high exactly when the machine is in the gap-complete state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| crs_i | input | 1 | Carrier sense, asynchronous |
| dfr_dis_i | input | 1 | 0 selects split deferral, 1 selects the fixed gap |
| enter_i | input | 1 | Entry request from the transmit process |
| enter_state_i | input | 3 | Target state code for an entry request |
| ifg_done_o | output | 1 | Gap complete, medium may be used |

## Verification
The hardest case to reach is carrier arriving right at the boundary between the two split phases. It restarts the gap in the final first-phase cycle and is ignored one cycle later. The synchroniser delay shifts this boundary relative to the pin. Directed runs place a carrier pulse at exactly the last and the first qualifying offsets after the carrier fall, and measure when the gap completes. Random carrier bursts, mode flips and entry requests with all eight codes then run against a cycle-level model of the requirements.

// File: rtl/carrier_defer_pkg.sv
package carrier_defer_pkg;
  typedef enum logic [2:0] {
    ST_BUSY = 3'd0,
    ST_GAP1 = 3'd1,
    ST_GAP2 = 3'd2,
    ST_GAPF = 3'd3,
    ST_DONE = 3'd4
  } dfr_state_e;

  localparam logic [2:0] ST_CODE_MAX = 3'd4;
endpackage

// File: rtl/cd_sync.sv
module cd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/cd_timer.sv
module cd_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;

  // hit on the last cycle of a phase; wraps to zero for the next phase
  assign hit_o = (cnt_q == limit_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (hit_o) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cd_fsm.sv
module cd_fsm
  import carrier_defer_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       crs_s_i,
  input  logic       dfr_dis_i,
  input  logic       entry_vld_i,
  input  dfr_state_e entry_st_i,
  input  logic       hit_i,
  output dfr_state_e state_o,
  output logic       tmr_clr_o
);
  dfr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (entry_vld_i) begin
      state_d = entry_st_i;
    end else begin
      unique case (state_q)
        ST_BUSY: if (!crs_s_i) state_d = dfr_dis_i ? ST_GAPF : ST_GAP1;
        ST_GAP1: begin
          if (crs_s_i)    state_d = ST_BUSY;
          else if (hit_i) state_d = ST_GAP2;
        end
        ST_GAP2: if (hit_i) state_d = ST_DONE;
        ST_GAPF: if (hit_i) state_d = ST_DONE;
        ST_DONE: if (crs_s_i) state_d = ST_BUSY;
        default: state_d = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_DONE;
    else         state_q <= state_d;
  end

  // timer idles outside timed states and restarts on any entry
  assign tmr_clr_o = entry_vld_i || (state_q == ST_BUSY) || (state_q == ST_DONE);
  assign state_o   = state_q;
endmodule

// File: rtl/carrier_defer.sv
module carrier_defer
  import carrier_defer_pkg::*;
#(
  parameter int CYC_PER_BIT = 10,
  parameter int BITS_PH1    = 64,
  parameter int BITS_PH2    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       crs_i,
  input  logic       dfr_dis_i,
  input  logic       enter_i,
  input  logic [2:0] enter_state_i,
  output logic       ifg_done_o
);
  localparam int CYC_PH1 = BITS_PH1 * CYC_PER_BIT;
  localparam int CYC_PH2 = BITS_PH2 * CYC_PER_BIT;
  localparam int CYC_FIX = CYC_PH1 + CYC_PH2;
  localparam int CNT_W   = $clog2(CYC_FIX + 1);

  logic             crs_s;
  logic             entry_vld;
  dfr_state_e       entry_st;
  dfr_state_e       state_q;
  logic             tmr_clr;
  logic             tmr_hit;
  logic [CNT_W-1:0] tmr_limit;

  cd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (crs_i),
    .q_o   (crs_s)
  );

  assign entry_vld = enter_i && (enter_state_i <= ST_CODE_MAX);
  assign entry_st  = dfr_state_e'(enter_state_i);

  always_comb begin
    unique case (state_q)
      ST_GAP1: tmr_limit = CNT_W'(CYC_PH1);
      ST_GAP2: tmr_limit = CNT_W'(CYC_PH2);
      default: tmr_limit = CNT_W'(CYC_FIX);
    endcase
  end

  cd_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tmr_clr),
    .limit_i(tmr_limit),
    .hit_o  (tmr_hit)
  );

  cd_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .crs_s_i    (crs_s),
    .dfr_dis_i  (dfr_dis_i),
    .entry_vld_i(entry_vld),
    .entry_st_i (entry_st),
    .hit_i      (tmr_hit),
    .state_o    (state_q),
    .tmr_clr_o  (tmr_clr)
  );

  assign ifg_done_o = (state_q == ST_DONE);
endmodule

// File: rtl/carrier_defer_chk.sv
module carrier_defer_chk
  import carrier_defer_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       crs_s,
  input logic       dfr_dis_i,
  input logic       entry_vld,
  input dfr_state_e entry_st,
  input dfr_state_e state_q,
  input logic       tmr_hit,
  input logic       ifg_done_o
);
  // R2 R4 R10: synchronised carrier forces busy from busy, first phase or done
  a_r2_carrier_to_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q inside {ST_BUSY, ST_GAP1, ST_DONE}) && crs_s && !entry_vld
    |=> state_q == ST_BUSY);

  a_r3_phase_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_GAP1 && tmr_hit && !crs_s && !entry_vld |=> state_q == ST_GAP2);

  a_r5_phase2_commits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_GAP2 && !entry_vld |=> state_q inside {ST_GAP2, ST_DONE});

  a_r6_fixed_commits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_GAPF && !entry_vld |=> state_q inside {ST_GAPF, ST_DONE});

  a_r7_mode_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_BUSY && !crs_s && !entry_vld
    |=> state_q == ($past(dfr_dis_i) ? ST_GAPF : ST_GAP1));

  a_r8_entry_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_vld |=> state_q == $past(entry_st));

  a_r10_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ifg_done_o && !crs_s && !entry_vld |=> ifg_done_o);
endmodule

bind carrier_defer carrier_defer_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .crs_s     (crs_s),
  .dfr_dis_i (dfr_dis_i),
  .entry_vld (entry_vld),
  .entry_st  (entry_st),
  .state_q   (state_q),
  .tmr_hit   (tmr_hit),
  .ifg_done_o(ifg_done_o)
);

// File: tb/carrier_defer_test.sv
`timescale 1ns/1ps
module carrier_defer_test;
  localparam int C    = 10;
  localparam int P1   = 64 * C;
  localparam int P2   = 32 * C;
  localparam int PF   = P1 + P2;
  localparam int GAP  = 3 + PF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic crs = 1'b0;
  logic dis = 1'b0;
  logic enter = 1'b0;
  logic [2:0] enter_st = 3'd0;
  logic done;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit model_on = 1'b0;

  always #5 clk = ~clk;

  carrier_defer #(.CYC_PER_BIT(C)) uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .crs_i        (crs),
    .dfr_dis_i    (dis),
    .enter_i      (enter),
    .enter_state_i(enter_st),
    .ifg_done_o   (done)
  );

  function automatic int dur(int st);
    case (st)
      1: return P1;
      2: return P2;
      3: return PF;
      default: return 0;
    endcase
  endfunction

  // reference model of the requirements: 0 busy 1 ph1 2 ph2 3 fixed 4 done
  int m_st = 4, m_rem = 0;
  bit m_s1 = 0, m_s2 = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 4; m_rem = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      if (enter && enter_st <= 3'd4) begin
        m_st = int'(enter_st); m_rem = dur(m_st);
      end else begin
        case (m_st)
          0: if (!m_s2) begin m_st = dis ? 3 : 1; m_rem = dur(m_st); end
          1: if (m_s2) m_st = 0;
             else if (m_rem == 1) begin m_st = 2; m_rem = P2; end
             else m_rem--;
          2, 3: if (m_rem == 1) m_st = 4; else m_rem--;
          default: if (m_s2) m_st = 0;
        endcase
      end
      m_s2 = m_s1; m_s1 = crs;
    end
  end

  always @(negedge clk) begin
    if (rst_n && model_on) begin
      tests++;
      if (done !== (m_st == 4)) begin
        fails++;
        $display("FAIL R11 model cycle %0d: done=%0b expected %0b", cycles, done, m_st == 4);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 190000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // carrier busy, then drop; optional pulse and mode flip; count edges to done
  task automatic gap_run(bit mode, int p_at, int p_len, int flip_at, int exp, string tag);
    int n = 0;
    @(negedge clk); crs = 1'b1; dis = mode;
    repeat (5) @(negedge clk);
    crs = 1'b0;
    forever begin
      @(posedge clk); n++;
      @(negedge clk);
      if (n == p_at) crs = 1'b1;
      if (n == p_at + p_len) crs = 1'b0;
      if (n == flip_at) dis = ~dis;
      if (done || n > 4000) break;
    end
    check(tag, n, exp);
  endtask

  // from idle, issue entry code, optional second code later, count edges to done
  task automatic enter_run(logic [2:0] c1, logic [2:0] c2, int at2, int exp, string tag);
    int n = 0;
    @(negedge clk); enter = 1'b1; enter_st = c1;
    forever begin
      @(posedge clk); n++;
      @(negedge clk);
      enter = (n == at2); enter_st = c2;
      if (done || n > 4000) break;
    end
    enter = 1'b0;
    check(tag, n, exp);
  endtask

  initial begin
    int hold;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    check("R1 reset done", int'(done), 1);
    rst_n = 1'b1;
    model_on = 1'b1;
    @(negedge clk);
    check("R1 done after release", int'(done), 1);

    // R2: synchroniser latency
    crs = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R2 done still high after 2 edges", int'(done), 1);
    @(posedge clk); @(negedge clk);
    check("R2 done low after 3 edges", int'(done), 0);
    repeat (50) @(negedge clk);
    check("R2 busy while carrier", int'(done), 0);
    crs = 1'b0;
    repeat (GAP + 5) @(negedge clk);

    gap_run(0, 0, 0, 0, GAP, "R3 split gap length");
    gap_run(0, 300, 5, 0, 305 + GAP, "R4 restart in phase one");
    gap_run(0, 640, 5, 0, 645 + GAP, "R4 last restart offset");
    gap_run(0, 641, 5, 0, GAP, "R5 first ignored offset");
    gap_run(0, 700, 5, 0, GAP, "R5 carrier in phase two");
    gap_run(1, 100, 5, 0, GAP, "R6 fixed ignores carrier");
    gap_run(1, 20, 900, 0, GAP, "R6 fixed long carrier");
    gap_run(1, 100, 5, 50, GAP, "R7 flip to split mid gap");
    gap_run(0, 0, 0, 50, GAP, "R7 flip to fixed mid gap");
    dis = 1'b0;

    enter_run(3'd2, 3'd0, -1, 1 + P2, "R8 enter phase two");
    enter_run(3'd3, 3'd0, -1, 1 + PF, "R8 enter fixed");
    enter_run(3'd0, 3'd0, -1, 2 + PF, "R8 enter busy");
    enter_run(3'd1, 3'd4, 10, 11, "R8 enter done mid gap");
    enter_run(3'd2, 3'd7, 10, 1 + P2, "R9 code 7 ignored");
    enter_run(3'd1, 3'd5, 200, 1 + PF, "R9 code 5 ignored");

    // R10: done holds with idle line and invalid requests
    hold = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      enter = (i % 7 == 0); enter_st = 3'd6;
      if (done) hold++;
    end
    enter = 1'b0;
    check("R10 done holds", hold, 300);

    // random traffic against the model (R11)
    for (int it = 0; it < 110; it++) begin
      int hi = 1 + ($urandom % 150);
      int lo = 1 + ($urandom % 1100);
      @(negedge clk); crs = 1'b1;
      if ($urandom % 4 == 0) dis = ~dis;
      repeat (hi) @(negedge clk);
      crs = 1'b0;
      for (int k = 0; k < lo; k++) begin
        @(negedge clk);
        enter = ($urandom % 160 == 0);
        enter_st = 3'($urandom % 8);
        if ($urandom % 90 == 0) crs = ~crs;
      end
      enter = 1'b0; crs = 1'b0;
    end
    repeat (GAP + 20) @(negedge clk);
    check("R11 idle after random", int'(done), 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule